// File: doc/BRIEF.md
# Parallel Flash Identification Probe Sequencer

This block is a small bus master that interrogates a 16-bit parallel NOR flash once software or boot logic asks it to. A single-cycle `start` launches a fixed sequence of bus operations on a plain synchronous memory port. First it unlocks the device and switches it into its query mode. There it reads the two version characters of the query table, which sits at a word address given on an input. It then sends the device back to array reads. Next it unlocks the device again and enters identification mode to read the manufacturer and device codes. Finally it returns the device to array reads.

Every mode change is preceded by the same three-write prefix. The first two writes carry fixed key bytes to two fixed word addresses. The third carries the mode command. Each write holds its address and data for a configurable number of cycles around a one-cycle write strobe. Each read uses a one-cycle read strobe and samples the low byte of the returned word a configurable number of cycles later. The four captured bytes, a busy flag, a one-cycle done pulse and an error flag are all registered outputs. The probe only supports the 16-bit device width. Any other configured width ends the probe at once with the error flag set and no bus traffic.

Top module: `flash_probe_seq`

## Requirements
- R1: During and after reset, busy, done, err, mem_we, mem_re and all four captured bytes are 0.
- R2: An accepted probe issues exactly twelve bus operations, in this order: write 0xAA to 0x5555, write 0x55 to 0x2AAA, write 0x98 to 0x5555 (query mode), read tbl_base+3, read tbl_base+4, write 0xF0 to 0x5555, write 0xAA to 0x5555, write 0x55 to 0x2AAA, write 0x90 to 0x5555 (identification mode), read word 0, read word 1, write 0xF0 to 0x5555. Write data carries the byte in bits 7:0 with bits 15:8 zero.
- R3: The low 8 bits of the read at tbl_base+3 appear on ver_major, and those of the read at tbl_base+4 appear on ver_minor. Bits 15:8 of the read data are discarded.
- R4: The device is returned to array reads (0xF0 to 0x5555) both between the query and identification phases and as the last operation.
- R5: The low 8 bits of the read at word 0 appear on mfr_code, and those of the read at word 1 appear on dev_code.
- R6: Each write drives mem_we for exactly one cycle. Address and data are stable for WR_SETUP cycles before that cycle and for WR_HOLD cycles after it.
- R7: Each read drives mem_re for exactly one cycle. The byte is taken from mem_rdata RD_LAT cycles after the strobe cycle.
- R8: The first operation starts two cycles after the cycle in which start is sampled. Each later operation starts two cycles after the previous one ends. A write spans WR_SETUP+WR_HOLD+1 cycles and a read spans RD_LAT+1 cycles. No strobe occurs outside these slots, and mem_we and mem_re are never high together.
- R9: busy is high from the cycle after an accepted start until the cycle before done. done is a one-cycle pulse in the second cycle after the last operation ends, and busy is low while done is high.
- R10: dev_type encodes 0 = x8, 1 = x16, 2 = x32, 3 = reserved. A start with any value other than 1 causes no bus operation, keeps busy low, and raises done and err in the next cycle.
- R11: A start that arrives while busy is high is ignored. The operation sequence and its timing continue unchanged.
- R12: Every start sampled while idle clears the four captured bytes and err in the next cycle. On the error path, err is then set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the probe |
| dev_type | input | 2 | Configured device width code (1 = x16) |
| tbl_base | input | ADDR_W | Word address of the query table |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_rdata | input | DATA_W | Memory read data, valid RD_LAT cycles after mem_re |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Probe refused because of device width |
| ver_major | output | 8 | Query table major version character |
| ver_minor | output | 8 | Query table minor version character |
| mfr_code | output | 8 | Manufacturer code |
| dev_code | output | 8 | Device code |

## Verification
The bench turns each accepted start in cycle s into an exact schedule. The first operation starts in cycle s+2. A write strobe falls WR_SETUP cycles into its slot and a read strobe falls in the first cycle of its slot. Each slot is followed by two idle cycles. done falls one cycle after the last slot's following cycle, and busy covers s+1 up to that point. On a refused start, done and err are due in s+1 and the captured bytes read zero there. Every cycle is compared against this schedule at the falling edge: no strobe outside a slot, the right kind and address inside one, stable address and data across the setup and hold window, and busy and done on their exact cycles. A behavioural flash model reacts only to the observed unlock and command writes and answers reads a cycle later with non-zero upper bytes. The captured bytes are compared at done against the values that model holds.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_OPS  = 12;
  localparam int NUM_SLOTS = 4;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_A         = 8'hAA;
  localparam logic [7:0]  KEY_B         = 8'h55;
  localparam logic [7:0]  CMD_QUERY     = 8'h98;
  localparam logic [7:0]  CMD_IDENT     = 8'h90;
  localparam logic [7:0]  CMD_ARRAY     = 8'hF0;
  localparam logic [15:0] VER_MAJ_OFS   = 16'd3;
  localparam logic [15:0] VER_MIN_OFS   = 16'd4;

  typedef enum logic [1:0] {
    DEV_X8   = 2'd0,
    DEV_X16  = 2'd1,
    DEV_X32  = 2'd2,
    DEV_RSVD = 2'd3
  } dev_type_e;

  typedef enum logic [1:0] {
    SLOT_VMAJ = 2'd0,
    SLOT_VMIN = 2'd1,
    SLOT_MFR  = 2'd2,
    SLOT_DEV  = 2'd3
  } cap_slot_e;

  typedef struct packed {
    logic        is_read;
    logic        rel;
    logic [1:0]  slot;
    logic [15:0] addr;
    logic [7:0]  data;
  } probe_op_t;

endpackage

// File: rtl/probe_op_table.sv
module probe_op_table
  import flash_probe_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output probe_op_t        op
);

  function automatic probe_op_t mk_wr(logic [15:0] a, logic [7:0] d);
    probe_op_t o;
    o.is_read = 1'b0;
    o.rel     = 1'b0;
    o.slot    = SLOT_VMAJ;
    o.addr    = a;
    o.data    = d;
    return o;
  endfunction

  function automatic probe_op_t mk_rd(logic r, logic [15:0] a, cap_slot_e s);
    probe_op_t o;
    o.is_read = 1'b1;
    o.rel     = r;
    o.slot    = s;
    o.addr    = a;
    o.data    = 8'h00;
    return o;
  endfunction

  always_comb begin
    case (idx)
      IDX_W'(0):  op = mk_wr(UNLOCK_ADDR_A, KEY_A);
      IDX_W'(1):  op = mk_wr(UNLOCK_ADDR_B, KEY_B);
      IDX_W'(2):  op = mk_wr(UNLOCK_ADDR_A, CMD_QUERY);
      IDX_W'(3):  op = mk_rd(1'b1, VER_MAJ_OFS, SLOT_VMAJ);
      IDX_W'(4):  op = mk_rd(1'b1, VER_MIN_OFS, SLOT_VMIN);
      IDX_W'(5):  op = mk_wr(UNLOCK_ADDR_A, CMD_ARRAY);
      IDX_W'(6):  op = mk_wr(UNLOCK_ADDR_A, KEY_A);
      IDX_W'(7):  op = mk_wr(UNLOCK_ADDR_B, KEY_B);
      IDX_W'(8):  op = mk_wr(UNLOCK_ADDR_A, CMD_IDENT);
      IDX_W'(9):  op = mk_rd(1'b0, 16'd0, SLOT_MFR);
      IDX_W'(10): op = mk_rd(1'b0, 16'd1, SLOT_DEV);
      default:    op = mk_wr(UNLOCK_ADDR_A, CMD_ARRAY);
    endcase
  end

endmodule

// File: rtl/probe_bus_engine.sv
module probe_bus_engine #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int WR_SETUP = 2,
  parameter int WR_HOLD  = 1,
  parameter int RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_read,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [BYTE_W-1:0] go_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              op_done,
  output logic [BYTE_W-1:0] rd_byte
);

  localparam int SPAN  = WR_SETUP + WR_HOLD + RD_LAT + 2;
  localparam int CNT_W = $clog2(SPAN) + 1;
  localparam logic [CNT_W-1:0] STROBE_AT = CNT_W'(WR_SETUP - 1);
  localparam logic [CNT_W-1:0] WR_END    = CNT_W'(WR_SETUP + WR_HOLD);
  localparam logic [CNT_W-1:0] RD_END    = CNT_W'(RD_LAT);

  typedef enum logic [1:0] {E_IDLE, E_WRITE, E_READ} eng_st_e;

  eng_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             unused_rd_hi;

  assign unused_rd_hi = ^bus_rdata[DATA_W-1:BYTE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      cnt       <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      op_done   <= 1'b0;
      rd_byte   <= '0;
    end else begin
      bus_we  <= 1'b0;
      bus_re  <= 1'b0;
      op_done <= 1'b0;
      case (st)
        E_IDLE: begin
          if (go) begin
            bus_addr <= go_addr;
            cnt      <= '0;
            if (go_read) begin
              st     <= E_READ;
              bus_re <= 1'b1;
            end else begin
              st        <= E_WRITE;
              bus_wdata <= DATA_W'(go_data);
            end
          end
        end
        E_WRITE: begin
          cnt <= cnt + 1'b1;
          if (cnt == STROBE_AT) bus_we <= 1'b1;
          if (cnt == WR_END) begin
            st      <= E_IDLE;
            op_done <= 1'b1;
          end
        end
        E_READ: begin
          cnt <= cnt + 1'b1;
          if (cnt == RD_END) begin
            rd_byte <= bus_rdata[BYTE_W-1:0];
            st      <= E_IDLE;
            op_done <= 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/probe_capture_bank.sv
module probe_capture_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int BYTE_W    = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               clr,
  input  logic                               wr_en,
  input  logic [SLOT_W-1:0]                  wr_slot,
  input  logic [BYTE_W-1:0]                  wr_byte,
  output logic [NUM_SLOTS-1:0][BYTE_W-1:0]   slots_q
);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slots_q[g] <= '0;
      end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
        slots_q[g] <= wr_byte;
      end
    end
  end

endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WR_SETUP = 2,
  parameter int WR_HOLD  = 1,
  parameter int RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        dev_type,
  input  logic [ADDR_W-1:0] tbl_base,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [7:0]        ver_major,
  output logic [7:0]        ver_minor,
  output logic [7:0]        mfr_code,
  output logic [7:0]        dev_code
);

  localparam int IDX_W  = $clog2(NUM_OPS);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_OPS - 1);

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} top_st_e;

  top_st_e                         st;
  logic [IDX_W-1:0]                idx;
  probe_op_t                       op;
  logic                            go;
  logic [ADDR_W-1:0]               go_addr;
  logic                            op_done;
  logic [BYTE_W-1:0]               rd_byte;
  logic                            accept;
  logic                            cap_we;
  logic [NUM_SLOTS-1:0][BYTE_W-1:0] caps;

  probe_op_table #(.IDX_W(IDX_W)) u_table (
    .idx (idx),
    .op  (op)
  );

  assign go      = (st == T_ISSUE);
  assign go_addr = op.rel ? (tbl_base + ADDR_W'(op.addr)) : ADDR_W'(op.addr);
  assign accept  = (st == T_IDLE) && start;
  assign cap_we  = (st == T_WAIT) && op_done && op.is_read;

  probe_bus_engine #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BYTE_W   (BYTE_W),
    .WR_SETUP (WR_SETUP),
    .WR_HOLD  (WR_HOLD),
    .RD_LAT   (RD_LAT)
  ) u_engine (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .go_read   (op.is_read),
    .go_addr   (go_addr),
    .go_data   (op.data),
    .bus_addr  (mem_addr),
    .bus_wdata (mem_wdata),
    .bus_we    (mem_we),
    .bus_re    (mem_re),
    .bus_rdata (mem_rdata),
    .op_done   (op_done),
    .rd_byte   (rd_byte)
  );

  probe_capture_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .BYTE_W    (BYTE_W)
  ) u_caps (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .wr_en   (cap_we),
    .wr_slot (SLOT_W'(op.slot)),
    .wr_byte (rd_byte),
    .slots_q (caps)
  );

  assign ver_major = caps[SLOT_VMAJ];
  assign ver_minor = caps[SLOT_VMIN];
  assign mfr_code  = caps[SLOT_MFR];
  assign dev_code  = caps[SLOT_DEV];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= T_IDLE;
      idx  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: begin
          if (start) begin
            if (dev_type == DEV_X16) begin
              busy <= 1'b1;
              err  <= 1'b0;
              idx  <= '0;
              st   <= T_ISSUE;
            end else begin
              done <= 1'b1;
              err  <= 1'b1;
            end
          end
        end
        T_ISSUE: st <= T_WAIT;
        T_WAIT: begin
          if (op_done) begin
            if (idx == LAST_IDX) begin
              st   <= T_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= T_ISSUE;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  a_r6_we_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r6_hold_after_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r7_re_single: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re);

  a_r8_strobe_only_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  a_r11_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

endmodule

bind flash_probe_seq flash_probe_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/test_flash_probe_seq.sv
`timescale 1ns/1ps
module test_flash_probe_seq;

  localparam int SU  = 2;
  localparam int HO  = 1;
  localparam int RL  = 1;
  localparam int NOP = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  dev_type = 2'd1;
  logic [15:0] tbl_base = 16'h0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, mem_re, busy, done, err;
  logic [7:0]  ver_major, ver_minor, mfr_code, dev_code;

  always #4 clk = ~clk;

  flash_probe_seq #(.WR_SETUP(SU), .WR_HOLD(HO), .RD_LAT(RL)) i_flash_probe_seq (
    .clk(clk), .rst(rst), .start(start), .dev_type(dev_type), .tbl_base(tbl_base),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .err(err),
    .ver_major(ver_major), .ver_minor(ver_minor), .mfr_code(mfr_code), .dev_code(dev_code));

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural flash: mode 0 array, 1 query, 2 identification
  int          fl_step = 0, fl_mode = 0;
  logic [15:0] fl_tbl = 0;
  logic [7:0]  fl_vmaj, fl_vmin, fl_mfr, fl_dev;

  function automatic logic [15:0] fl_read(logic [15:0] a);
    if (fl_mode == 1) begin
      if (a == fl_tbl + 16'd3) return {8'hEE, fl_vmaj};
      if (a == fl_tbl + 16'd4) return {8'hEE, fl_vmin};
      return {8'hEE, 8'h5A ^ a[7:0]};
    end
    if (fl_mode == 2) begin
      if (a == 16'd0) return {8'hC4, fl_mfr};
      if (a == 16'd1) return {8'hC4, fl_dev};
      return 16'h0033;
    end
    return ~a;
  endfunction

  // expected operations and schedule
  bit          op_wr[NOP];
  logic [15:0] op_a[NOP];
  logic [7:0]  op_d[NOP];
  int          sched[NOP];
  int          nxt = NOP, done_cyc = -1, s_cyc = -100;
  bit          run_good = 0, mon_on = 0, done_seen = 0;
  int          hold_left = 0;
  logic [15:0] hold_a, hold_d;
  logic [15:0] hist_a[4], hist_d[4];

  task automatic set_op(input int k, input bit w, input logic [15:0] a, input logic [7:0] d);
    op_wr[k] = w; op_a[k] = a; op_d[k] = d;
  endtask

  task automatic build_ops(input logic [15:0] base);
    set_op(0, 1, 16'h5555, 8'hAA);  set_op(1, 1, 16'h2AAA, 8'h55);
    set_op(2, 1, 16'h5555, 8'h98);  set_op(3, 0, base + 16'd3, 8'h00);
    set_op(4, 0, base + 16'd4, 8'h00); set_op(5, 1, 16'h5555, 8'hF0);
    set_op(6, 1, 16'h5555, 8'hAA);  set_op(7, 1, 16'h2AAA, 8'h55);
    set_op(8, 1, 16'h5555, 8'h90);  set_op(9, 0, 16'h0000, 8'h00);
    set_op(10, 0, 16'h0001, 8'h00); set_op(11, 1, 16'h5555, 8'hF0);
  endtask

  always @(negedge clk) begin
    if (rst) begin
      fl_step = 0; fl_mode = 0; mem_rdata = 16'h0;
    end else if (mon_on) begin
      bit strobe_slot;
      // flash reacts to the observed bus
      if (mem_we) begin
        if (mem_wdata[7:0] == 8'hF0) begin fl_mode = 0; fl_step = 0; end
        else if (fl_step == 0 && mem_addr == 16'h5555 && mem_wdata[7:0] == 8'hAA) fl_step = 1;
        else if (fl_step == 1 && mem_addr == 16'h2AAA && mem_wdata[7:0] == 8'h55) fl_step = 2;
        else if (fl_step == 2 && mem_addr == 16'h5555 && mem_wdata[7:0] == 8'h98) begin fl_mode = 1; fl_step = 0; end
        else if (fl_step == 2 && mem_addr == 16'h5555 && mem_wdata[7:0] == 8'h90) begin fl_mode = 2; fl_step = 0; end
        else fl_step = 0;
      end
      if (mem_re) mem_rdata = fl_read(mem_addr);
      // hold window after a write strobe (R6)
      if (hold_left > 0) begin
        chk(mem_addr == hold_a && mem_wdata == hold_d, "R6 hold", mem_addr, hold_a);
        hold_left--;
      end
      // strobe schedule (R2, R4, R5, R7, R8)
      strobe_slot = (nxt < NOP) && (cyc == sched[nxt]);
      if (strobe_slot) begin
        if (op_wr[nxt]) begin
          chk(mem_we && !mem_re, "R8 write strobe slot", {mem_we, mem_re}, 2);
          chk(mem_addr == op_a[nxt], "R2 write addr", mem_addr, op_a[nxt]);
          chk(mem_wdata == {8'h00, op_d[nxt]}, "R2 write data", mem_wdata, op_d[nxt]);
          for (int i = 0; i < SU; i++)
            chk(hist_a[i] == mem_addr && hist_d[i] == mem_wdata, "R6 setup", hist_a[i], mem_addr);
          hold_left = HO; hold_a = mem_addr; hold_d = mem_wdata;
        end else begin
          chk(mem_re && !mem_we, "R7 read strobe slot", {mem_we, mem_re}, 1);
          chk(mem_addr == op_a[nxt], "R3 read addr", mem_addr, op_a[nxt]);
        end
        nxt++;
      end else begin
        chk(!mem_we && !mem_re, "R8 no strobe outside slot", {mem_we, mem_re}, 0);
      end
      // busy / done per cycle (R9, R10, R11)
      chk(busy == (run_good && cyc > s_cyc && cyc < done_cyc), "R9 busy", busy,
          (run_good && cyc > s_cyc && cyc < done_cyc));
      chk(done == (cyc == done_cyc), "R9 done", done, (cyc == done_cyc));
      if (cyc == done_cyc) begin
        done_seen = 1;
        chk(err == !run_good, "R10 err at done", err, !run_good);
      end
      if (cyc == s_cyc + 1) begin
        chk({ver_major, ver_minor, mfr_code, dev_code} == 32'h0, "R12 bytes cleared",
            {ver_major, ver_minor, mfr_code, dev_code}, 0);
        chk(err == !run_good, "R12 err cleared or set", err, !run_good);
      end
      for (int i = 3; i > 0; i--) begin hist_a[i] = hist_a[i-1]; hist_d[i] = hist_d[i-1]; end
      hist_a[0] = mem_addr; hist_d[0] = mem_wdata;
    end
  end

  task automatic run_probe(input logic [1:0] dt, input logic [15:0] base,
                           input logic [7:0] vma, input logic [7:0] vmi,
                           input logic [7:0] mf, input logic [7:0] dv, input bit mid_start);
    int t, waited;
    fl_tbl = base; fl_vmaj = vma; fl_vmin = vmi; fl_mfr = mf; fl_dev = dv;
    build_ops(base);
    @(negedge clk);
    dev_type = dt; tbl_base = base; start = 1'b1;
    s_cyc = cyc; done_seen = 0;
    run_good = (dt == 2'd1);
    if (run_good) begin
      t = s_cyc + 2;
      for (int k = 0; k < NOP; k++) begin
        sched[k] = t + (op_wr[k] ? SU : 0);
        t += (op_wr[k] ? (SU + HO + 1) : (RL + 1)) + 2;
      end
      done_cyc = t - 1;
      nxt = 0;
    end else begin
      done_cyc = s_cyc + 1;
      nxt = NOP;
    end
    @(negedge clk);
    start = 1'b0;
    if (mid_start) begin
      repeat (10) @(negedge clk);
      start = 1'b1;            // R11: must be ignored
      dev_type = 2'd0;
      @(negedge clk);
      start = 1'b0;
      dev_type = dt;
    end
    waited = 0;
    while (!done_seen && waited < 2000) begin @(negedge clk); waited++; end
    chk(done_seen, "R9 done reached (watchdog)", done_seen, 1);
    @(negedge clk);
    chk(nxt == (run_good ? NOP : NOP), "R2 all operations seen", nxt, NOP);
    if (run_good) begin
      chk(ver_major == vma, "R3 ver_major", ver_major, vma);
      chk(ver_minor == vmi, "R3 ver_minor", ver_minor, vmi);
      chk(mfr_code == mf, "R5 mfr_code", mfr_code, mf);
      chk(dev_code == dv, "R5 dev_code", dev_code, dv);
      chk(fl_mode == 0, "R4 device back in array mode", fl_mode, 0);
      chk(err == 1'b0, "R10 err low on x16", err, 0);
    end else begin
      chk(err == 1'b1, "R10 err held", err, 1);
      chk({ver_major, ver_minor, mfr_code, dev_code} == 32'h0, "R12 bytes zero after refusal",
          {ver_major, ver_minor, mfr_code, dev_code}, 0);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({busy, done, err, mem_we, mem_re} == 5'b0, "R1 reset flags", {busy, done, err, mem_we, mem_re}, 0);
    chk({ver_major, ver_minor, mfr_code, dev_code} == 32'h0, "R1 reset bytes",
        {ver_major, ver_minor, mfr_code, dev_code}, 0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin hist_a[i] = 16'h0; hist_d[i] = 16'h0; end
    @(negedge clk);
    mon_on = 1;
    repeat (3) @(negedge clk);
    run_probe(2'd1, 16'h0010, 8'h31, 8'h30, 8'hBF, 8'hD7, 0);
    run_probe(2'd1, 16'h0040, 8'h32, 8'h35, 8'h01, 8'h7E, 1);
    run_probe(2'd0, 16'h0010, 8'h31, 8'h30, 8'hBF, 8'hD7, 0);
    run_probe(2'd2, 16'h0010, 8'h31, 8'h30, 8'hBF, 8'hD7, 0);
    run_probe(2'd1, 16'h5552, 8'h33, 8'h31, 8'h89, 8'h18, 0);
    run_probe(2'd3, 16'h0000, 8'h31, 8'h30, 8'hBF, 8'hD7, 0);
    run_probe(2'd1, 16'hFFF0, 8'h34, 8'h36, 8'h20, 8'hC5, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule